// File: doc/BRIEF.md
# Framed Byte Stream Depacketizer

This block takes a byte stream in which every frame is wrapped by a one-byte opening marker and a one-byte closing marker. It removes both markers and passes only the payload bytes to a downstream stream port. Frame boundaries move from in-band marker bytes to an end-of-frame flag on the output, so the consumer sees ordinary stream packets.

The closing marker arrives after the last payload byte, but the flag must be set on that last byte. The block therefore keeps each payload byte in a one-entry pending register. The byte moves to a registered output stage, flagged as not last, when the next payload byte arrives. It moves flagged as last when the closing marker arrives. Both ports use a valid/ready handshake, one byte per beat, on a single clock with an active-low asynchronous reset.

Top module: `frame_unwrap`

## Requirements
- R1: While reset is held and right after it is released, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Outside a frame, every byte other than the opening marker 0xFF is accepted with `in_ready_o` high and dropped, producing no output beat.
- R3: Payload bytes (any value other than 0xFF and 0xF1) inside a frame come out in arrival order, each exactly once. The marker bytes 0xFF and 0xF1 are never output.
- R4: `out_last_o` is 1 on the final payload byte of each frame (the byte just before 0xF1) and 0 on every other beat.
- R5: A frame with exactly one payload byte yields exactly one output beat, with `out_last_o` = 1.
- R6: An opening marker followed directly by a closing marker yields no output beat.
- R7: An opening marker received inside a frame discards the pending byte and starts a new frame. Bytes already moved to the output stage are still delivered.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_data_o` and `out_last_o` hold their values on the next cycle.
- R9: `in_ready_o` is 0 only when a payload byte is pending and the output stage holds a beat that is not being taken (`out_valid_o` = 1, `out_ready_i` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Incoming byte |
| in_valid_i | input | 1 | Incoming byte valid |
| in_ready_o | output | 1 | Block accepts incoming byte |
| out_data_o | output | 8 | Payload byte |
| out_valid_o | output | 1 | Payload byte valid |
| out_ready_i | input | 1 | Downstream accepts payload byte |
| out_last_o | output | 1 | Final payload byte of the frame |

## Verification
If the pending register or the frame state is wrong, the effect shows at the output port one cycle after the byte that exposes it. A frame state stuck inside a frame shows as stalled or leaked bytes between frames. A lost pending flag shows as a missing beat, or as a missing last flag when the closing marker arrives. A missed restart shows as a discarded byte reappearing. The scoreboard compares every output beat, data and flag, against a byte-level model under both free-running and randomly stalled downstream ready. It also checks that stalled beats hold steady and that input stalls happen only when the register pair is full.

// File: rtl/frame_unwrap_pkg.sv
package frame_unwrap_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BODY = 1'b1
  } fu_state_e;
endpackage

// File: rtl/frame_unwrap_ctrl.sv
module frame_unwrap_ctrl
  import frame_unwrap_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] SOF_BYTE = 8'hFF,
  parameter logic [DATA_W-1:0] EOF_BYTE = 8'hF1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              take_i,
  output fu_state_e         state_o,
  output logic              pay_o,
  output logic              end_o,
  output logic              restart_o
);
  fu_state_e state_q;
  logic is_sof, is_eof, in_body;

  always_comb begin
    is_sof    = (byte_i == SOF_BYTE);
    is_eof    = (byte_i == EOF_BYTE);
    in_body   = (state_q == ST_BODY);
    pay_o     = take_i && in_body && !is_sof && !is_eof;
    end_o     = take_i && in_body && is_eof;
    restart_o = take_i && in_body && is_sof;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else if (take_i) begin
      if (!in_body && is_sof)     state_q <= ST_BODY;
      else if (in_body && is_eof) state_q <= ST_IDLE;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/frame_unwrap_hold.sv
module frame_unwrap_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              pay_i,
  input  logic              end_i,
  input  logic              restart_i,
  input  logic              out_ready_i,
  output logic              in_ready_o,
  output logic              pend_full_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_last_o
);
  logic [DATA_W-1:0] pend_q, out_q;
  logic pend_full_q, out_valid_q, out_last_q;
  logic move, out_free;

  assign out_free   = !out_valid_q || out_ready_i;
  assign in_ready_o = !(pend_full_q && !out_free);
  assign move       = (pay_i || end_i) && pend_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      pend_full_q <= 1'b0;
      out_q       <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
    end else begin
      if (out_valid_q && out_ready_i) out_valid_q <= 1'b0;
      if (move) begin
        out_q       <= pend_q;
        out_last_q  <= end_i;
        out_valid_q <= 1'b1;
      end
      if (pay_i) begin
        pend_q      <= byte_i;
        pend_full_q <= 1'b1;
      end else if (end_i || restart_i) begin
        pend_full_q <= 1'b0;
      end
    end
  end

  assign pend_full_o = pend_full_q;
  assign out_data_o  = out_q;
  assign out_valid_o = out_valid_q;
  assign out_last_o  = out_last_q;

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_q && !out_ready_i |=> out_valid_q && $stable(out_q) && $stable(out_last_q));
endmodule

// File: rtl/frame_unwrap.sv
module frame_unwrap
  import frame_unwrap_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [DATA_W-1:0] SOF_BYTE = 8'hFF,
  parameter logic [DATA_W-1:0] EOF_BYTE = 8'hF1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_last_o
);
  fu_state_e state;
  logic take, pay, fin, restart, pend_full;

  assign take = in_valid_i && in_ready_o;

  frame_unwrap_ctrl #(
    .DATA_W(DATA_W), .SOF_BYTE(SOF_BYTE), .EOF_BYTE(EOF_BYTE)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(in_data_i), .take_i(take),
    .state_o(state), .pay_o(pay), .end_o(fin), .restart_o(restart)
  );

  frame_unwrap_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(in_data_i),
    .pay_i(pay), .end_i(fin), .restart_i(restart),
    .out_ready_i(out_ready_i), .in_ready_o(in_ready_o), .pend_full_o(pend_full),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_last_o(out_last_o)
  );

  // R2
  idle_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IDLE |-> in_ready_o && !pend_full);
  // R3
  beat_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));
  // R4
  last_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && pend_full |=> out_valid_o && out_last_o && state == ST_IDLE);
  // R6
  empty_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && !pend_full && (!out_valid_o || out_ready_i) |=> !out_valid_o);
endmodule

// File: tb/frame_unwrap_test.sv
`timescale 1ns/1ps
module frame_unwrap_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic       out_last_o;

  always #2.5 clk_i = ~clk_i;

  frame_unwrap uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_last_o(out_last_o)
  );

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R3";
  logic [8:0] exp_q[$];
  bit m_in = 0, m_pend = 0;
  logic [7:0] m_pd = '0;
  bit bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: push bytes, model the expected output
  task automatic send(input logic [7:0] b);
    in_data_i  = b;
    in_valid_i = 1'b1;
    forever begin
      @(negedge clk_i);
      if (!m_in) chk(in_ready_o == 1'b1, "R2 idle ready", int'(in_ready_o), 1);
      if (in_ready_o) break;
      @(posedge clk_i); #1;
    end
    @(posedge clk_i); #1;
    in_valid_i = 1'b0;
    if (!m_in) begin
      if (b == 8'hFF) begin m_in = 1; m_pend = 0; end
    end else if (b == 8'hFF) begin
      m_pend = 0;
    end else if (b == 8'hF1) begin
      if (m_pend) exp_q.push_back({m_pd, 1'b1});
      m_pend = 0; m_in = 0;
    end else begin
      if (m_pend) exp_q.push_back({m_pd, 1'b0});
      m_pend = 1; m_pd = b;
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk_i);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // downstream ready
  always @(posedge clk_i) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i = bp_mode ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  bit prev_stall = 0;
  logic [7:0] prev_d = '0;
  logic prev_l = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_stall)
        chk(out_valid_o && out_data_o == prev_d && out_last_o == prev_l, "R8 hold",
            {out_valid_o, out_data_o, out_last_o}, {1'b1, prev_d, prev_l});
      if (!in_ready_o)
        chk(out_valid_o && !out_ready_i, "R9 stall cause", {out_valid_o, out_ready_i}, 2'b10);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {cur_req, " unexpected beat"}, {out_data_o, out_last_o}, 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({out_data_o, out_last_o} == e, {cur_req, " data/last"}, {out_data_o, out_last_o}, e);
        end
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_d = out_data_o;
      prev_l = out_last_o;
    end
  end

  // watchdog
  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 during reset
    chk(out_valid_o == 0 && in_ready_o == 1, "R1 in reset", {out_valid_o, in_ready_o}, 2'b01);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 0 && in_ready_o == 1, "R1 after reset", {out_valid_o, in_ready_o}, 2'b01);

    // R2: garbage before any start marker
    cur_req = "R2";
    send(8'h12); send(8'hF1); send(8'h55); send(8'h00);
    drain("R2 drain");
    repeat (3) begin
      @(negedge clk_i);
      chk(!out_valid_o, "R2 no output", int'(out_valid_o), 0);
    end

    // R3 R4: plain frame
    cur_req = "R3 R4 frame";
    send(8'hFF); send(8'h10); send(8'h20); send(8'h30); send(8'hF1);
    drain("R3 drain");

    // R5: single payload byte
    cur_req = "R5 single";
    send(8'hFF); send(8'h04); send(8'hF1);
    drain("R5 drain");

    // R6: empty frame
    cur_req = "R6 empty";
    send(8'hFF); send(8'hF1);
    repeat (4) begin
      @(negedge clk_i);
      chk(!out_valid_o, "R6 no output", int'(out_valid_o), 0);
    end

    // R7: restart inside a frame (0x01 released, 0x02 dropped)
    cur_req = "R7 restart";
    send(8'hFF); send(8'h01); send(8'h02); send(8'hFF); send(8'h03); send(8'hF1);
    drain("R7 drain");

    // R8 R9: randomly stalled downstream, back to back frames
    bp_mode = 1;
    cur_req = "R8 backpressure";
    for (int f = 0; f < 6; f++) begin
      send(8'hFF);
      for (int k = 0; k <= f * 3; k++) send(8'((f * 17 + k * 5) & 8'h7F));
      send(8'hF1);
    end
    send(8'hFF); send(8'h7F); send(8'hF1);
    drain("R8 drain");
    bp_mode = 0;

    summary();
  end
endmodule